// File: doc/BRIEF.md
# Serial Peripheral Master with Word Queues

This block is a processor-side SPI master. Software talks to it through a small word-wide register port. Words written to the data register wait in a transmit queue. Each word the serializer shifts out brings back one word from the MISO line, and that word lands in a receive queue that software drains by reading the same data register. The usual driver pattern is: write up to four words, wait until the serializer reports idle (or until the receive-level interrupt fires), then read the same number of words back.

The controller has two operating modes, set by a two-bit mode field:

- **Configuration** (`01`). The word length and clock divider can be changed, and no serial activity starts.
- **Active** (`10`). Queued words are shifted out.

Per-word settings are clock polarity, clock phase, bit order and an 8- or 16-bit word length. The divider `n` (1..255) sets each SCK half-cycle to `n` clock cycles. Chip select is driven elsewhere.

The serializer is a three-state machine:

| State | What happens | Leaves when |
|---|---|---|
| `SH_IDLE` | SCK is held at the polarity level. | A word is waiting, the mode is active and no stop is requested (`start`). It then pops a word and goes to `SH_FIRST`. |
| `SH_FIRST` | SCK is at its idle level. | `n` cycles have passed (`half_done`). It makes the leading edge and goes to `SH_SECOND`. |
| `SH_SECOND` | SCK is at its active level. | `n` cycles have passed. It makes the trailing edge, then returns to `SH_FIRST` for the next bit, or to `SH_IDLE` after the last bit, when it pushes the received word. |

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the registers read as follows: mode/command register (offset 0x00) = 0x40, i.e. configuration mode; format register (0x04) = 0x0004; timing register (0x08) = 0x0408; status register (0x14) = 0x8004. The irq output is low and SCK is low.
- R2: No SCK edge occurs unless the mode field (bits 7:6 of 0x00) holds `10`. In configuration mode, written words only accumulate in the transmit queue.
- R3: A write to the timing register takes effect only when the mode field holds `01`. In any other mode the write is ignored. The divider is in bits 15:8. Writing 16 to bits 4:0 selects 16-bit words, and any other value selects 8-bit words.
- R4: Each queue holds 4 words. A data-register write while the transmit queue is full is dropped, and that word never appears on MOSI.
- R5: MOSI carries the word's low 8 or 16 bits. The order is most significant bit first when format bit 2 is 1, and least significant bit first when it is 0.
- R6: Between transfers, SCK rests at format bit 0 (polarity). Within a word, consecutive SCK edges are exactly `n` clock cycles apart.
- R7: Format bit 1 (phase) selects the data edge. When it is 0, data is valid on the leading edge and sampled there. When it is 1, data changes on the leading edge and is sampled on the trailing edge.
- R8: Each transmitted word pushes one word sampled from MISO into the receive queue. Reading the data register (0x18) pops that word, zero-extended above the word length.
- R9: Status bit 14 is set while the receive count is at least the format field in bits 13:12 plus 1. The irq output equals status bit 14 ANDed with format bit 9.
- R10: If a word completes while the receive queue is full, the word is dropped and status bit 7 is set. Writing 1 to status bit 7 clears it.
- R11: Writing the mode/command register with bit 0 set empties both queues in one cycle.
- R12: While mode/command bit 1 (stop) is set, no new word is started.
- R13: The status register reports the transmit count in bits 13:11 and the receive count in bits 10:8. Bit 15 is set when the transmit queue is empty. Bit 2 is set when the serializer is idle and the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops at data offset) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as addr |
| irq | output | 1 | Receive-level interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A serializer that leaves `SH_IDLE` at the wrong time shows up in one of two ways: as SCK edges while in configuration or stop, or as a transmit count that stays non-zero in status. A bit index or edge selection that is wrong corrupts the first word's MOSI pattern. A wrong half-cycle count breaks the `n`-cycle spacing of the very next SCK edge. Queue-pointer or count faults appear at the next status read as wrong occupancy or wrong level flags, and at the next data read as a wrong or repeated word. A MISO loopback through an inverter ties every received word to its transmitted one.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam logic [7:0] OFS_MODE   = 8'h00;
    localparam logic [7:0] OFS_FMT    = 8'h04;
    localparam logic [7:0] OFS_TIMING = 8'h08;
    localparam logic [7:0] OFS_STAT   = 8'h14;
    localparam logic [7:0] OFS_DATA   = 8'h18;

    localparam logic [1:0] MODE_CFG = 2'b01;
    localparam logic [1:0] MODE_ACT = 2'b10;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_FIRST,
        SH_SECOND
    } sh_state_t;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       msb_first;
        logic       wide;
        logic [7:0] div;
    } ser_cfg_t;

    function automatic logic [3:0] bit_at(logic wide, logic msb, logic [3:0] k);
        logic [3:0] top;
        top = wide ? 4'd15 : 4'd7;
        return msb ? (top - k) : k;
    endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int WMAX = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ser_cfg_t        cfg,
    input  logic            go_ok,
    input  logic            tx_valid,
    input  logic [WMAX-1:0] tx_word,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [WMAX-1:0] rx_word,
    output logic            sck,
    output logic            mosi,
    input  logic            miso,
    output logic            idle
);
    sh_state_t       state, nstate;
    logic [7:0]      cnt;
    logic [3:0]      k;
    logic [WMAX-1:0] txw, rxw, rx_nxt;
    logic            wide_q, msb_q, cpha_q, sck_q, mosi_q;
    logic            start, half_done, last;
    logic [3:0]      cur;
    logic [7:0]      div_eff;

    assign div_eff   = (cfg.div == 8'd0) ? 8'd1 : cfg.div;
    assign half_done = (cnt == div_eff - 8'd1);
    assign start     = (state == SH_IDLE) && tx_valid && go_ok;
    assign last      = (k == (wide_q ? 4'd15 : 4'd7));
    assign cur       = bit_at(wide_q, msb_q, k);

    always_comb begin
        rx_nxt = rxw;
        if (cpha_q) rx_nxt[cur] = miso;
    end

    assign tx_pop  = start;
    assign rx_push = (state == SH_SECOND) && half_done && last;
    assign rx_word = rx_nxt;
    assign sck     = sck_q;
    assign mosi    = mosi_q;
    assign idle    = (state == SH_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            SH_IDLE:   if (start)     nstate = SH_FIRST;
            SH_FIRST:  if (half_done) nstate = SH_SECOND;
            SH_SECOND: if (half_done) nstate = last ? SH_IDLE : SH_FIRST;
            default:                  nstate = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; k <= '0; txw <= '0; rxw <= '0;
            wide_q <= 1'b0; msb_q <= 1'b1; cpha_q <= 1'b0;
            sck_q <= 1'b0; mosi_q <= 1'b0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    sck_q <= cfg.cpol;
                    if (start) begin
                        txw    <= tx_word;
                        rxw    <= '0;
                        k      <= '0;
                        cnt    <= '0;
                        wide_q <= cfg.wide;
                        msb_q  <= cfg.msb_first;
                        cpha_q <= cfg.cpha;
                        if (!cfg.cpha)
                            mosi_q <= tx_word[bit_at(cfg.wide, cfg.msb_first, 4'd0)];
                    end
                end
                SH_FIRST: begin
                    if (half_done) begin
                        cnt   <= '0;
                        sck_q <= ~sck_q;
                        if (!cpha_q) rxw[cur] <= miso;
                        else         mosi_q   <= txw[cur];
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                SH_SECOND: begin
                    if (half_done) begin
                        cnt   <= '0;
                        sck_q <= ~sck_q;
                        rxw   <= rx_nxt;
                        if (!last) begin
                            k <= k + 4'd1;
                            if (!cpha_q)
                                mosi_q <= txw[bit_at(wide_q, msb_q, k + 4'd1)];
                        end
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int WMAX = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    logic [1:0] mode_q;
    logic       stop_q, cpol_q, cpha_q, msb_q, ie_q, wide_q, ovr_q;
    logic [1:0] lvl_q;
    logic [7:0] div_q;

    logic            wr_mode, wr_fmt, wr_tim, wr_stat, wr_data, rd_data, clr_q;
    logic [WMAX-1:0] tx_din, tx_dout, rx_word, rx_dout;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            tx_pop, rx_push, sh_idle, rx_lvl;
    ser_cfg_t        cfg;

    assign wr_mode = wr_en && (addr == AW'(OFS_MODE));
    assign wr_fmt  = wr_en && (addr == AW'(OFS_FMT));
    assign wr_tim  = wr_en && (addr == AW'(OFS_TIMING));
    assign wr_stat = wr_en && (addr == AW'(OFS_STAT));
    assign wr_data = wr_en && (addr == AW'(OFS_DATA));
    assign rd_data = rd_en && (addr == AW'(OFS_DATA));
    assign clr_q   = wr_mode && wdata[0];
    assign tx_din  = wide_q ? wdata[15:0] : {8'h00, wdata[7:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_CFG; stop_q <= 1'b0;
            cpol_q <= 1'b0; cpha_q <= 1'b0; msb_q <= 1'b1; ie_q <= 1'b0; lvl_q <= 2'd0;
            div_q  <= 8'd4; wide_q <= 1'b0; ovr_q <= 1'b0;
        end else begin
            if (wr_mode) begin
                mode_q <= wdata[7:6];
                stop_q <= wdata[1];
            end
            if (wr_fmt) begin
                cpol_q <= wdata[0];
                cpha_q <= wdata[1];
                msb_q  <= wdata[2];
                ie_q   <= wdata[9];
                lvl_q  <= wdata[13:12];
            end
            if (wr_tim && mode_q == MODE_CFG) begin
                div_q  <= wdata[15:8];
                wide_q <= (wdata[4:0] == 5'd16);
            end
            if (rx_push && rx_full)       ovr_q <= 1'b1;
            else if (wr_stat && wdata[7]) ovr_q <= 1'b0;
        end
    end

    assign cfg = '{cpol: cpol_q, cpha: cpha_q, msb_first: msb_q, wide: wide_q, div: div_q};

    spim_fifo #(.W(WMAX), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr_q), .push(wr_data), .din(tx_din),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(WMAX), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr_q), .push(rx_push), .din(rx_word),
        .pop(rd_data), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_shifter #(.WMAX(WMAX)) u_shift (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .go_ok((mode_q == MODE_ACT) && !stop_q),
        .tx_valid(!tx_empty), .tx_word(tx_dout), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .sck(sck), .mosi(mosi), .miso(miso), .idle(sh_idle)
    );

    assign rx_lvl = ({1'b0, rx_cnt} >= ({1'b0, CW'(lvl_q)} + 1'b1));
    assign irq    = rx_lvl && ie_q;

    always_comb begin
        rdata = '0;
        unique case (addr)
            AW'(OFS_MODE):   rdata[7:0]  = {mode_q, 4'b0, stop_q, 1'b0};
            AW'(OFS_FMT):    rdata[15:0] = {2'b0, lvl_q, 2'b0, ie_q, 6'b0, msb_q, cpha_q, cpol_q};
            AW'(OFS_TIMING): rdata[15:0] = {div_q, 3'b0, (wide_q ? 5'd16 : 5'd8)};
            AW'(OFS_STAT):   rdata[15:0] = {tx_empty, rx_lvl, 3'(tx_cnt), 3'(rx_cnt), ovr_q,
                                            4'b0, (sh_idle && tx_empty), 2'b0};
            AW'(OFS_DATA):   rdata[15:0] = rx_empty ? 16'h0 : rx_dout;
            default:         rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sck,
    input logic          irq,
    input logic          sh_idle,
    input logic          cpol_q,
    input logic [1:0]    mode_q,
    input logic          ie_q,
    input logic          ovr_q,
    input logic          rx_full,
    input logic          rx_push,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt
);
    // R6
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_idle && $past(sh_idle)) |-> (sck == $past(cpol_q)));

    // R2
    cfg_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'b10 && sh_idle) |=> sh_idle);

    // R4
    tx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_cnt) <= DEPTH));

    // R10
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(rx_full && rx_push));

    // R9
    irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_q);

    // R8
    rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) || (int'(rx_cnt) <= int'($past(rx_cnt)) + 1));
endmodule

bind spi_fifo_master spim_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sck), .irq(irq), .sh_idle(sh_idle),
    .cpol_q(cpol_q), .mode_q(mode_q), .ie_q(ie_q), .ovr_q(ovr_q),
    .rx_full(rx_full), .rx_push(rx_push), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;
    logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        irq, sck, mosi, miso;

    always #4 clk = ~clk;
    assign miso = ~mosi;

    spi_fifo_master dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
        .sck(sck), .mosi(mosi), .miso(miso));

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic cpol_g = 0, cpha_g = 0, msb_g = 1, wide_g = 0, mon_en = 0;
    int   div_g = 4;
    int   sck_edges = 0;
    logic [15:0] ser_q[$];
    logic [15:0] rx_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: serial scoreboard
    logic sck_prev = 0;
    int   cyc = 0, edge_in_word = 0, nb = 0;
    logic [15:0] rec = 0;
    always @(negedge clk) begin
        if (rst_n && mon_en && sck !== sck_prev) begin
            sck_edges++;
            if (edge_in_word > 0)
                chk(cyc + 1 == div_g, "R6 edge spacing", cyc + 1, div_g);
            edge_in_word++;
            if (cpha_g ? (sck == cpol_g) : (sck != cpol_g)) begin
                if (msb_g) rec = {rec[14:0], mosi};
                else       rec[nb] = mosi;
                nb++;
                if (nb == (wide_g ? 16 : 8)) begin
                    if (ser_q.size() == 0) chk(0, "R4/R5 unexpected word", rec, 0);
                    else begin
                        logic [15:0] e;
                        e = ser_q.pop_front();
                        chk(rec == e, "R5/R7 serial word", rec, e);
                    end
                    nb = 0; rec = 0;
                end
            end
            if (edge_in_word == (wide_g ? 32 : 16)) edge_in_word = 0;
            cyc = 0;
        end else cyc++;
        sck_prev = sck;
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic send(input logic [15:0] w);
        logic [15:0] m;
        m = wide_g ? 16'hFFFF : 16'h00FF;
        bus_wr(8'h18, {16'h0, w});
        ser_q.push_back(w & m);
        rx_q.push_back(~w & m);
    endtask

    task automatic rd_rx(input string req);
        logic [31:0] d;
        logic [15:0] e;
        bus_rd(8'h18, d);
        e = rx_q.pop_front();
        chk(d == {16'h0, e}, req, d, {16'h0, e});
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            bus_rd(8'h14, s);
            if (s[2]) return;
        end
        chk(0, "R13 idle timeout", 0, 1);
    endtask

    task automatic set_cfg(input logic [31:0] fmt, input logic [31:0] tim);
        mon_en = 0;
        bus_wr(8'h00, 32'h40);
        bus_wr(8'h04, fmt);
        bus_wr(8'h08, tim);
        cpol_g = fmt[0]; cpha_g = fmt[1]; msb_g = fmt[2];
        wide_g = (tim[4:0] == 5'd16); div_g = (tim[15:8] == 0) ? 1 : int'(tim[15:8]);
        repeat (3) @(negedge clk);
        mon_en = 1; edge_in_word = 0; nb = 0; rec = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        bus_rd(8'h00, d); chk(d == 32'h40, "R1 mode reg", d, 32'h40);
        bus_rd(8'h04, d); chk(d == 32'h0004, "R1 format reg", d, 32'h0004);
        bus_rd(8'h08, d); chk(d == 32'h0408, "R1 timing reg", d, 32'h0408);
        bus_rd(8'h14, d); chk(d == 32'h8004, "R1 status", d, 32'h8004);
        chk(irq == 0 && sck == 0, "R1 irq/sck", {irq, sck}, 0);
        mon_en = 1;
        // R2 config mode holds words
        bus_wr(8'h18, 32'h11); bus_wr(8'h18, 32'h22);
        repeat (40) @(negedge clk);
        bus_rd(8'h14, d); chk(d == 32'h1000, "R2 R13 status tx=2", d, 32'h1000);
        chk(sck_edges == 0, "R2 no sck in config", sck_edges, 0);
        // R11 clear
        bus_wr(8'h00, 32'h41);
        bus_rd(8'h14, d); chk(d == 32'h8004, "R11 cleared", d, 32'h8004);
        // R3 timing writes
        set_cfg(32'h0004, 32'h0208);
        bus_rd(8'h08, d); chk(d == 32'h0208, "R3 write in config", d, 32'h0208);
        bus_wr(8'h00, 32'h80);
        bus_wr(8'h08, 32'h0510);
        bus_rd(8'h08, d); chk(d == 32'h0208, "R3 write ignored active", d, 32'h0208);
        // 8-bit, mode 0, msb first
        send(16'hA5); send(16'h3C); send(16'h81); send(16'h0F);
        wait_idle();
        bus_rd(8'h14, d); chk(d == 32'hC404, "R13 R9 status rx=4", d, 32'hC404);
        repeat (4) rd_rx("R8 rx 8-bit");
        // 16-bit, cpol1 cpha1, lsb first
        set_cfg(32'h0003, 32'h0310);
        chk(sck == 1, "R6 idle level cpol1", sck, 1);
        bus_wr(8'h00, 32'h80);
        send(16'hBEEF); send(16'h1234); send(16'h8001);
        wait_idle();
        repeat (3) rd_rx("R8 rx 16-bit");
        // R4 overflow of tx queue
        set_cfg(32'h0006, 32'h0110);
        send(16'h0101); send(16'h0202); send(16'h0303); send(16'h0404);
        bus_wr(8'h18, 32'hDEAD);
        bus_rd(8'h14, d); chk(d == 32'h2000, "R4 tx full count", d, 32'h2000);
        bus_wr(8'h00, 32'h80);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(ser_q.size() == 0, "R4 dropped word absent", ser_q.size(), 0);
        bus_rd(8'h14, d); chk(d[10:8] == 3'd4, "R4 rx count", d[10:8], 4);
        repeat (4) rd_rx("R8 rx after R4");
        // R9 level irq, level 2
        set_cfg(32'h1204, 32'h0108);
        bus_wr(8'h00, 32'h80);
        send(16'h55); wait_idle();
        bus_rd(8'h14, d);
        chk(irq == 0 && d[14] == 0, "R9 below level", {irq, d[14]}, 0);
        send(16'h66); wait_idle();
        chk(irq == 1, "R9 level reached", irq, 1);
        rd_rx("R8 rx level");
        @(negedge clk);
        chk(irq == 0, "R9 flag drops", irq, 0);
        rd_rx("R8 rx level 2");
        // R10 overrun
        send(16'h01); send(16'h02); send(16'h03); send(16'h04); wait_idle();
        send(16'h05); wait_idle();
        bus_rd(8'h14, d); chk(d[7] == 1 && d[10:8] == 3'd4, "R10 overrun set", d, 32'h0480);
        bus_wr(8'h14, 32'h80);
        bus_rd(8'h14, d); chk(d[7] == 0, "R10 overrun cleared", d[7], 0);
        bus_wr(8'h00, 32'h81); rx_q.delete();
        bus_rd(8'h14, d); chk(d[10:8] == 0, "R11 rx cleared", d[10:8], 0);
        // R12 stop
        bus_wr(8'h00, 32'h82);
        e0 = sck_edges;
        send(16'h9A);
        repeat (60) @(negedge clk);
        bus_rd(8'h14, d);
        chk(sck_edges == e0 && d[13:11] == 3'd1, "R12 stop holds", d[13:11], 1);
        bus_wr(8'h00, 32'h80);
        wait_idle();
        rd_rx("R12 R8 resumed word");
        repeat (10) @(negedge clk);
        chk(ser_q.size() == 0, "R5 all words seen", ser_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule